// File: doc/BRIEF.md
# Stack-Push Opcode Recogniser

This block watches a stream of instruction bytes, one byte per clock when `byte_valid` is high. It works out whether the bytes encode a push-to-stack operation, and if so which kind. Four operand classes are reported:

- a general register,
- a memory operand,
- a segment register,
- an immediate.

For each push it also reports the register or segment number, the immediate width and the full instruction length in bytes. Displacement and immediate bytes are not consumed. Their count is folded into the reported length, so that a fetch unit can skip past them.

Decoding starts from a single opcode byte. Two cases need a second byte:

- An escape byte must be followed by a second opcode byte.
- The group opcode is qualified by the `reg` field of the ModRM byte that follows it. The `mod` and `rm` fields of that byte set the displacement length.

`size32` gives the current operand size. It is sampled together with the byte that completes the decode. It selects a 2- or 4-byte word immediate and a 2- or 4-byte full displacement.

Any byte sequence that is not a push produces a one-cycle `not_push` pulse, and the recogniser returns to waiting for an opcode.

Top module: `push_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, `done` and `not_push` are 0.
- R2: An opcode byte 0x50..0x57 gives, one cycle after it is accepted, a `done` pulse with `op_class`=0 (general register), `reg_idx`=byte[2:0] and `insn_len`=1.
- R3: Opcode bytes 0x06, 0x0E, 0x16 and 0x1E give `done` with `op_class`=2 (segment), `reg_idx` 0, 1, 2 and 3 respectively, and `insn_len`=1.
- R4: Escape byte 0x0F followed by 0xA0 or 0xA8 gives `done` with `op_class`=2, `reg_idx` 4 or 5 respectively, and `insn_len`=2. The pulse comes only after the second byte; no output pulses after the escape byte itself.
- R5: Opcode 0x6A gives `op_class`=3 (immediate), `imm_bytes`=1 and `insn_len`=2. Opcode 0x68 gives `imm_bytes`=4 and `insn_len`=5 when `size32`=1, and `imm_bytes`=2 and `insn_len`=3 when `size32`=0.
- R6: Byte 0xFF followed by a ModRM byte with `reg` (bits 5:3) equal to 6 and `mod` (bits 7:6) not 3 gives `op_class`=1 (memory), `reg_idx`=rm (bits 2:0) and `insn_len`=2+disp. Here disp is 1 for mod=1. It is the full size (4 if `size32`, else 2) for mod=2, or for mod=0 with rm=5. It is 0 for any other mod=0 case.
- R7: Byte 0xFF followed by a ModRM byte with mod=3 and reg=6 gives `op_class`=0, `reg_idx`=rm and `insn_len`=2.
- R8: Each of the following gives a one-cycle `not_push` pulse and no `done`:
  - a first byte that is none of the above opcodes;
  - 0xFF followed by a ModRM byte whose reg field is not 6;
  - 0x0F followed by any byte other than 0xA0 or 0xA8.

  After the pulse, the very next byte is decoded as an opcode.
- R9: Cycles with `byte_valid` low produce no pulse and leave a partly decoded sequence pending. The sequence completes correctly when its next byte arrives.
- R10: `done` and `not_push` are never high together. A new instruction may start on the cycle right after a `done`, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | `byte_in` carries an instruction byte this cycle |
| byte_in | input | 8 | Instruction byte |
| size32 | input | 1 | Current operand size is 32 bits (0: 16 bits) |
| done | output | 1 | One-cycle pulse: a push was recognised, result fields valid |
| not_push | output | 1 | One-cycle pulse: the sequence is not a push |
| op_class | output | 2 | 0 general register, 1 memory, 2 segment, 3 immediate |
| reg_idx | output | 3 | Register number, segment number, or ModRM rm field |
| imm_bytes | output | IMM_W (3) | Immediate bytes following the opcode |
| insn_len | output | LEN_W (4) | Total instruction length in bytes |

## Verification
Directed sequences cover each opcode family on its own. The escape and group paths are driven with a valid and an invalid second byte, which separates a correct two-byte walk from one that decides too early or forgets its state. Every ModRM `mod` value is applied, together with the rm=5 special case, at both operand sizes, so that wrong displacement or immediate widths show up in the reported length. Random streams mix well-formed pushes, stray bytes and idle gaps, with `size32` flipping every cycle. These runs expose recovery faults after a rejection, lost pending state across gaps, and any dependence on an operand size sampled at the wrong byte.

// File: rtl/push_dec_pkg.sv
package push_dec_pkg;

    typedef enum logic [1:0] {
        CLS_GPR = 2'd0,
        CLS_MEM = 2'd1,
        CLS_SEG = 2'd2,
        CLS_IMM = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_ESCAPE = 2'd1,
        ST_MODRM  = 2'd2
    } dec_state_e;

    localparam logic [7:0] OPC_ESCAPE  = 8'h0F;
    localparam logic [7:0] OPC_GROUP   = 8'hFF;
    localparam logic [7:0] OPC_IMM8    = 8'h6A;
    localparam logic [7:0] OPC_IMMW    = 8'h68;
    localparam logic [4:0] OPC_GPR_HI  = 5'b01010;
    localparam logic [2:0] GROUP_PUSH  = 3'd6;
    localparam logic [2:0] SEG2_BASE   = 3'd4;

endpackage

// File: rtl/push_first_byte.sv
module push_first_byte
    import push_dec_pkg::*;
#(
    parameter int IMM_W = 3,
    parameter int LEN_W = 4
) (
    input  logic [7:0]       opc,
    input  logic             size32,
    output logic             complete,
    output logic             escape,
    output logic             group,
    output op_class_e        cls,
    output logic [2:0]       idx,
    output logic [IMM_W-1:0] imm,
    output logic [LEN_W-1:0] len
);

    localparam logic [IMM_W-1:0] IMM_ONE  = IMM_W'(1);
    localparam logic [IMM_W-1:0] IMM_WORD = IMM_W'(2);
    localparam logic [IMM_W-1:0] IMM_DWRD = IMM_W'(4);

    always_comb begin
        complete = 1'b0;
        escape   = 1'b0;
        group    = 1'b0;
        cls      = CLS_GPR;
        idx      = 3'd0;
        imm      = '0;
        len      = LEN_W'(1);
        if (opc[7:3] == OPC_GPR_HI) begin
            complete = 1'b1;
            idx      = opc[2:0];
        end else if (opc[7:5] == 3'b000 && opc[2:0] == 3'b110) begin
            complete = 1'b1;
            cls      = CLS_SEG;
            idx      = {1'b0, opc[4:3]};
        end else if (opc == OPC_IMM8) begin
            complete = 1'b1;
            cls      = CLS_IMM;
            imm      = IMM_ONE;
            len      = LEN_W'(1) + LEN_W'(IMM_ONE);
        end else if (opc == OPC_IMMW) begin
            complete = 1'b1;
            cls      = CLS_IMM;
            imm      = size32 ? IMM_DWRD : IMM_WORD;
            len      = LEN_W'(1) + LEN_W'(size32 ? IMM_DWRD : IMM_WORD);
        end else if (opc == OPC_ESCAPE) begin
            escape = 1'b1;
        end else if (opc == OPC_GROUP) begin
            group = 1'b1;
        end
    end

endmodule

// File: rtl/push_modrm_len.sv
module push_modrm_len
    import push_dec_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic [7:0]       modrm,
    input  logic             size32,
    output logic             is_push,
    output logic             reg_form,
    output logic [LEN_W-1:0] len
);

    localparam logic [LEN_W-1:0] BASE_LEN = LEN_W'(2);

    logic [1:0]       mod_f;
    logic [2:0]       rm_f;
    logic [LEN_W-1:0] full_disp;
    logic [LEN_W-1:0] disp;

    assign mod_f     = modrm[7:6];
    assign rm_f      = modrm[2:0];
    assign is_push   = (modrm[5:3] == GROUP_PUSH);
    assign reg_form  = (mod_f == 2'b11);
    assign full_disp = size32 ? LEN_W'(4) : LEN_W'(2);

    always_comb begin
        unique case (mod_f)
            2'b00:   disp = (rm_f == 3'b101) ? full_disp : '0;
            2'b01:   disp = LEN_W'(1);
            2'b10:   disp = full_disp;
            default: disp = '0;
        endcase
        len = BASE_LEN + disp;
    end

endmodule

// File: rtl/push_decoder.sv
module push_decoder
    import push_dec_pkg::*;
#(
    parameter int IMM_W = 3,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_in,
    input  logic             size32,
    output logic             done,
    output logic             not_push,
    output logic [1:0]       op_class,
    output logic [2:0]       reg_idx,
    output logic [IMM_W-1:0] imm_bytes,
    output logic [LEN_W-1:0] insn_len
);

    typedef struct packed {
        dec_state_e       state;
        logic             done;
        logic             not_push;
        op_class_e        cls;
        logic [2:0]       idx;
        logic [IMM_W-1:0] imm;
        logic [LEN_W-1:0] len;
    } dec_regs_t;

    localparam dec_regs_t REGS_RESET = '{
        state: ST_OPCODE, done: 1'b0, not_push: 1'b0, cls: CLS_GPR,
        idx: 3'd0, imm: '0, len: '0
    };

    dec_regs_t regs_d, regs_q;

    logic             fb_complete, fb_escape, fb_group;
    op_class_e        fb_cls;
    logic [2:0]       fb_idx;
    logic [IMM_W-1:0] fb_imm;
    logic [LEN_W-1:0] fb_len;

    logic             mr_push, mr_reg;
    logic [LEN_W-1:0] mr_len;

    push_first_byte #(.IMM_W(IMM_W), .LEN_W(LEN_W)) u_first (
        .opc      (byte_in),
        .size32   (size32),
        .complete (fb_complete),
        .escape   (fb_escape),
        .group    (fb_group),
        .cls      (fb_cls),
        .idx      (fb_idx),
        .imm      (fb_imm),
        .len      (fb_len)
    );

    push_modrm_len #(.LEN_W(LEN_W)) u_modrm (
        .modrm    (byte_in),
        .size32   (size32),
        .is_push  (mr_push),
        .reg_form (mr_reg),
        .len      (mr_len)
    );

    always_comb begin
        regs_d          = regs_q;
        regs_d.done     = 1'b0;
        regs_d.not_push = 1'b0;
        if (byte_valid) begin
            unique case (regs_q.state)
                ST_OPCODE: begin
                    if (fb_complete) begin
                        regs_d.done = 1'b1;
                        regs_d.cls  = fb_cls;
                        regs_d.idx  = fb_idx;
                        regs_d.imm  = fb_imm;
                        regs_d.len  = fb_len;
                    end else if (fb_escape) begin
                        regs_d.state = ST_ESCAPE;
                    end else if (fb_group) begin
                        regs_d.state = ST_MODRM;
                    end else begin
                        regs_d.not_push = 1'b1;
                    end
                end
                ST_ESCAPE: begin
                    regs_d.state = ST_OPCODE;
                    if ((byte_in & 8'hF7) == 8'hA0) begin
                        regs_d.done = 1'b1;
                        regs_d.cls  = CLS_SEG;
                        regs_d.idx  = SEG2_BASE + {2'b00, byte_in[3]};
                        regs_d.imm  = '0;
                        regs_d.len  = LEN_W'(2);
                    end else begin
                        regs_d.not_push = 1'b1;
                    end
                end
                ST_MODRM: begin
                    regs_d.state = ST_OPCODE;
                    if (mr_push) begin
                        regs_d.done = 1'b1;
                        regs_d.cls  = mr_reg ? CLS_GPR : CLS_MEM;
                        regs_d.idx  = byte_in[2:0];
                        regs_d.imm  = '0;
                        regs_d.len  = mr_len;
                    end else begin
                        regs_d.not_push = 1'b1;
                    end
                end
                default: begin
                    regs_d.state = ST_OPCODE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    assign done      = regs_q.done;
    assign not_push  = regs_q.not_push;
    assign op_class  = regs_q.cls;
    assign reg_idx   = regs_q.idx;
    assign imm_bytes = regs_q.imm;
    assign insn_len  = regs_q.len;

endmodule

// File: rtl/push_decoder_chk.sv
module push_decoder_chk #(
    parameter int IMM_W = 3,
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic             done,
    input logic             not_push,
    input logic [1:0]       op_class,
    input logic [2:0]       reg_idx,
    input logic [IMM_W-1:0] imm_bytes,
    input logic [LEN_W-1:0] insn_len
);

    // R10
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && not_push));

    // R9
    pulse_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || not_push) |-> $past(byte_valid));

    // R5
    imm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_class == 2'd3) |-> (insn_len == LEN_W'(imm_bytes) + LEN_W'(1)));

    // R3
    seg_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_class == 2'd2) |->
            ((reg_idx < 3'd4 && insn_len == LEN_W'(1)) ||
             ((reg_idx == 3'd4 || reg_idx == 3'd5) && insn_len == LEN_W'(2))));

    // R6
    mem_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_class == 2'd1) |->
            (insn_len >= LEN_W'(2) && insn_len <= LEN_W'(6) && imm_bytes == '0));

    // R2
    gpr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_class == 2'd0) |-> (insn_len == LEN_W'(1) || insn_len == LEN_W'(2)));

endmodule

bind push_decoder push_decoder_chk #(.IMM_W(IMM_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .done       (done),
    .not_push   (not_push),
    .op_class   (op_class),
    .reg_idx    (reg_idx),
    .imm_bytes  (imm_bytes),
    .insn_len   (insn_len)
);

// File: tb/tb_push_decoder.sv
module tb_push_decoder;

    localparam int IMM_W = 3;
    localparam int LEN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             byte_valid = 1'b0;
    logic [7:0]       byte_in = 8'h00;
    logic             size32 = 1'b0;
    logic             done, not_push;
    logic [1:0]       op_class;
    logic [2:0]       reg_idx;
    logic [IMM_W-1:0] imm_bytes;
    logic [LEN_W-1:0] insn_len;

    int n_vec  = 0;
    int n_fail = 0;
    int m_st   = 0;   // model: 0 opcode, 1 after escape, 2 after group
    bit finished = 1'b0;

    always #10 clk = ~clk;

    push_decoder #(.IMM_W(IMM_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .size32(size32), .done(done), .not_push(not_push), .op_class(op_class),
        .reg_idx(reg_idx), .imm_bytes(imm_bytes), .insn_len(insn_len)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model(input bit v, input logic [7:0] b, input bit sz,
                         output bit e_done, output bit e_np, output int e_cls,
                         output int e_idx, output int e_imm, output int e_len,
                         output string tag);
        e_done = 0; e_np = 0; e_cls = 0; e_idx = 0; e_imm = 0; e_len = 0;
        tag = (m_st == 0) ? "R9" : "R9_pending";
        if (!v) return;
        if (m_st == 0) begin
            tag = "R8";
            if (b >= 8'h50 && b <= 8'h57) begin
                e_done = 1; e_cls = 0; e_idx = int'(b) - 'h50; e_len = 1; tag = "R2";
            end else if (b == 8'h06 || b == 8'h0E || b == 8'h16 || b == 8'h1E) begin
                e_done = 1; e_cls = 2; e_len = 1; tag = "R3";
                case (b)
                    8'h06: e_idx = 0;
                    8'h0E: e_idx = 1;
                    8'h16: e_idx = 2;
                    default: e_idx = 3;
                endcase
            end else if (b == 8'h6A) begin
                e_done = 1; e_cls = 3; e_imm = 1; e_len = 2; tag = "R5";
            end else if (b == 8'h68) begin
                e_done = 1; e_cls = 3; e_imm = sz ? 4 : 2; e_len = 1 + e_imm; tag = "R5";
            end else if (b == 8'h0F) begin
                m_st = 1; tag = "R4";
            end else if (b == 8'hFF) begin
                m_st = 2; tag = "R6";
            end else begin
                e_np = 1;
            end
        end else if (m_st == 1) begin
            m_st = 0;
            if (b == 8'hA0) begin e_done = 1; e_cls = 2; e_idx = 4; e_len = 2; tag = "R4"; end
            else if (b == 8'hA8) begin e_done = 1; e_cls = 2; e_idx = 5; e_len = 2; tag = "R4"; end
            else begin e_np = 1; tag = "R8"; end
        end else begin
            int md, rg, rm, dsp;
            m_st = 0;
            md = int'(b[7:6]); rg = int'(b[5:3]); rm = int'(b[2:0]);
            if (rg != 6) begin
                e_np = 1; tag = "R8";
            end else if (md == 3) begin
                e_done = 1; e_cls = 0; e_idx = rm; e_len = 2; tag = "R7";
            end else begin
                if (md == 1) dsp = 1;
                else if (md == 2 || rm == 5) dsp = sz ? 4 : 2;
                else dsp = 0;
                e_done = 1; e_cls = 1; e_idx = rm; e_len = 2 + dsp; tag = "R6";
            end
        end
    endtask

    // Called at a negedge; returns at the following negedge after checking.
    task automatic send(input bit v, input logic [7:0] b, input bit sz);
        bit ed, en; int ec, ei, em, el; string tag;
        model(v, b, sz, ed, en, ec, ei, em, el, tag);
        byte_valid = v; byte_in = b; size32 = sz;
        @(posedge clk);
        @(negedge clk);
        check(tag, "done", int'(done), int'(ed));
        check((tag == "R2" || tag == "R8") ? "R10" : tag, "not_push", int'(not_push), int'(en));
        if (ed && done) begin
            check(tag, "op_class", int'(op_class), ec);
            check(tag, "reg_idx", int'(reg_idx), ei);
            check(tag, "imm_bytes", int'(imm_bytes), em);
            check(tag, "insn_len", int'(insn_len), el);
        end
    endtask

    function automatic logic [7:0] rand_push_opcode(input int k);
        case (k)
            0: return 8'h50 + 8'($urandom_range(0, 7));
            1: begin
                int s = $urandom_range(0, 3);
                return 8'(s * 8 + 6);
            end
            2: return 8'h6A;
            default: return 8'h68;
        endcase
    endfunction

    task automatic maybe_gap();
        if ($urandom_range(0, 4) == 0) send(1'b0, 8'($urandom), 1'($urandom));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet during reset
        check("R1", "done in reset", int'(done), 0);
        check("R1", "not_push in reset", int'(not_push), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "not_push after reset", int'(not_push), 0);

        // R2 every general register, back to back (R10)
        for (int i = 0; i < 8; i++) send(1'b1, 8'h50 + 8'(i), 1'b0);
        // R3 classic segments
        send(1'b1, 8'h06, 1'b0); send(1'b1, 8'h0E, 1'b1);
        send(1'b1, 8'h16, 1'b0); send(1'b1, 8'h1E, 1'b1);
        // R4 escape forms, one with a gap (R9)
        send(1'b1, 8'h0F, 1'b0); send(1'b1, 8'hA0, 1'b0);
        send(1'b1, 8'h0F, 1'b1); send(1'b0, 8'hA8, 1'b0); send(1'b0, 8'h00, 1'b0);
        send(1'b1, 8'hA8, 1'b1);
        // R5 immediates, both sizes
        send(1'b1, 8'h6A, 1'b1); send(1'b1, 8'h68, 1'b0); send(1'b1, 8'h68, 1'b1);
        // R6 every mod, rm=5 special, both sizes
        send(1'b1, 8'hFF, 1'b0); send(1'b1, 8'h30, 1'b0);
        send(1'b1, 8'hFF, 1'b0); send(1'b1, 8'h35, 1'b0);
        send(1'b1, 8'hFF, 1'b1); send(1'b1, 8'h35, 1'b1);
        send(1'b1, 8'hFF, 1'b0); send(1'b1, 8'h75, 1'b1);
        send(1'b1, 8'hFF, 1'b1); send(1'b1, 8'hB4, 1'b1);
        send(1'b1, 8'hFF, 1'b0); send(1'b0, 8'h36, 1'b1); send(1'b1, 8'hB4, 1'b0);
        // R7 register form through the group opcode
        send(1'b1, 8'hFF, 1'b0); send(1'b1, 8'hF3, 1'b0);
        // R8 rejections, each followed at once by a valid opcode
        send(1'b1, 8'hC3, 1'b0); send(1'b1, 8'h53, 1'b0);
        send(1'b1, 8'hFF, 1'b0); send(1'b1, 8'h20, 1'b0); send(1'b1, 8'h6A, 1'b0);
        send(1'b1, 8'h0F, 1'b0); send(1'b1, 8'h05, 1'b0); send(1'b1, 8'h0E, 1'b0);
        send(1'b1, 8'h0F, 1'b0); send(1'b1, 8'h0F, 1'b0); send(1'b1, 8'h57, 1'b0);
        send(1'b1, 8'hFF, 1'b0); send(1'b1, 8'hFF, 1'b0); send(1'b1, 8'h50, 1'b0);

        // Random mix of pushes, stray bytes and gaps
        for (int n = 0; n < 3000; n++) begin
            int k = $urandom_range(0, 9);
            if (k < 4) begin
                send(1'b1, rand_push_opcode(k), 1'($urandom));
            end else if (k < 6) begin
                send(1'b1, 8'h0F, 1'($urandom)); maybe_gap();
                send(1'b1, ($urandom_range(0, 3) == 0) ? 8'($urandom)
                           : ($urandom_range(0, 1) ? 8'hA0 : 8'hA8), 1'($urandom));
            end else if (k < 8) begin
                logic [7:0] mr = 8'($urandom);
                if ($urandom_range(0, 3) != 0) mr[5:3] = 3'd6;
                send(1'b1, 8'hFF, 1'($urandom)); maybe_gap();
                send(1'b1, mr, 1'($urandom));
            end else begin
                send(1'b1, 8'($urandom), 1'($urandom));
            end
            maybe_gap();
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule